// File: doc/BRIEF.md
# Command-Response Buffer Register Front End

This block is the memory-mapped front end of a trusted-platform style command-response buffer. Software reaches it through a simple MMIO slave port. Each access carries a 16-bit address and a byte count of 1 to 8. Writes take effect at the clock edge. Read data is combinational from the address. The block holds the ownership state of the single supported locality, a control-request and status pair, start and cancel doorbells, the programmable command and response window registers, two read-only identification words, and a byte-addressed data buffer that begins at offset 0x80.

Software fills the buffer, takes ownership, and writes the start doorbell. The block then offers the buffer and its running byte count to a backend on a valid/ready request port, and waits for a one-cycle done pulse. On that pulse it writes the response bytes into the buffer and clears the start bit. A nonzero result code sets a sticky error bit. The command processing itself lives in the backend.

Top module: `crb_front`

## Requirements
- R1: After reset the locality state word reads 0x80 (valid bit 7 set, assigned bit 1 clear) while the backend reports established, the control status word reads 0x2 (idle bit 1 set, error bit 0 clear) and the start word reads 0.
- R2: The interface ID word at 0x30 reads 0x00025811, the second ID word at 0x34 reads 0x00001014, and writes to either are ignored and flagged on `mmio_err_o`.
- R3: After reset the command size (0x58) and response size (0x64) words hold the window size minus 0x80, the command low address (0x5C) and response address (0x68) words hold the base address plus 0x80, and command high address (0x60) holds 0. All five are writable with little-endian data of 1 to 4 bytes, and bytes not written read as zero.
- R4: Value 1 written to locality control (0x08) sets assigned (state bit 1) and granted (status word 0x0C bit 0) and clears been-seized (bit 1). Value 2 clears assigned and granted. Value 8 changes nothing. Every other value changes nothing and raises `mmio_err_o`.
- R5: Value 1 written to control request (0x40) clears the idle bit. Value 2 sets it. Every other value leaves it unchanged and raises `mmio_err_o`.
- R6: A write of 1 to the start word (0x4C) is accepted only under three conditions: the start bit is 0, the locality is assigned, and address bits 15:12 equal the active locality 0. An unassigned locality reads as 0xFF, so no start can match. Rejected starts change nothing.
- R7: An accepted start sets start bit 0 and drives `bk_req_valid_o`. The valid stays high until `bk_req_ready_i`. While it is high, the port presents the buffer contents, the running length and the locality.
- R8: A `bk_done_i` pulse after the request was taken clears the start bit, copies `bk_rsp_data_i` into the buffer, and sets status error bit 0 if `bk_result_i` is nonzero. The error bit then stays set.
- R9: A write of 1 to cancel (0x48) pulses `bk_cancel_o` one cycle later, but only while the start bit is set.
- R10: A buffer write must lie wholly inside 0x80..0x80+BUF_BYTES-1. A write starting exactly at 0x80 first zeroes the buffer and the running length. Every buffer write adds its byte count to the length. Buffer reads return up to 4 bytes, little-endian.
- R11: While the start bit is set, buffer writes are ignored and raise `mmio_err_o`. This holds even in the cycle the done pulse arrives.
- R12: A register write longer than 4 bytes is rejected with `mmio_err_o`. The one exception is the response address word, which takes the low 4 bytes.
- R13: Offsets below 0x80 that the map does not define read as zero. Writes to them are ignored and raise `mmio_err_o`.
- R14: Locality state bit 0 reads as 1 whenever `est_flag_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mmio_req_i | input | 1 | Access strobe |
| mmio_we_i | input | 1 | 1 = write, 0 = read |
| mmio_addr_i | input | 16 | Byte offset; bits 15:12 give the locality |
| mmio_len_i | input | 4 | Byte count, 1 to 8 |
| mmio_wdata_i | input | 64 | Write data, little-endian |
| mmio_rdata_o | output | 32 | Read data, little-endian |
| mmio_err_o | output | 1 | Current write is rejected |
| est_flag_i | input | 1 | Backend established flag |
| bk_req_valid_o | output | 1 | Command request valid |
| bk_req_ready_i | input | 1 | Backend takes the request |
| bk_locality_o | output | 4 | Locality of the command |
| bk_cmd_len_o | output | 16 | Running command length |
| bk_cmd_data_o | output | BUF_BYTES*8 | Buffer contents, byte 0 in the low bits |
| bk_cancel_o | output | 1 | One-cycle cancel request |
| bk_done_i | input | 1 | Response complete pulse |
| bk_result_i | input | 8 | Result code, 0 = success |
| bk_rsp_data_i | input | BUF_BYTES*8 | Response bytes |

## Verification
Two functions can meet in one cycle: the backend's done pulse and a software write into the data buffer. The bench raises `bk_done_i` on the same edge at which it drives a byte write to offset 0x80. That write would otherwise zero the buffer and reset the length. The write must be flagged, the buffer must hold the response bytes, and the running length must keep its value. The bench also issues a cancel while a request is still waiting for ready, and another after completion, to show that the pulse follows the start bit.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam logic [7:0] OFS_LOC_STATE = 8'h00;
  localparam logic [7:0] OFS_LOC_CTRL  = 8'h08;
  localparam logic [7:0] OFS_LOC_STS   = 8'h0C;
  localparam logic [7:0] OFS_ID        = 8'h30;
  localparam logic [7:0] OFS_ID2       = 8'h34;
  localparam logic [7:0] OFS_REQ       = 8'h40;
  localparam logic [7:0] OFS_STS       = 8'h44;
  localparam logic [7:0] OFS_CANCEL    = 8'h48;
  localparam logic [7:0] OFS_START     = 8'h4C;
  localparam logic [7:0] OFS_CMD_SIZE  = 8'h58;
  localparam logic [7:0] OFS_CMD_LO    = 8'h5C;
  localparam logic [7:0] OFS_CMD_HI    = 8'h60;
  localparam logic [7:0] OFS_RSP_SIZE  = 8'h64;
  localparam logic [7:0] OFS_RSP_ADDR  = 8'h68;
  localparam logic [11:0] BUF_BASE     = 12'h080;

  typedef enum logic [1:0] {BK_IDLE, BK_REQ, BK_WAIT} bk_state_e;

  function automatic logic [31:0] le_word(input logic [31:0] d, input logic [3:0] n);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 4; i++) if (i < int'(n)) w[i*8 +: 8] = d[i*8 +: 8];
    return w;
  endfunction
endpackage

// File: rtl/crb_dbuf.sv
module crb_dbuf #(
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       wofs_i,
  input  logic [3:0]             wlen_i,
  input  logic [63:0]            wdata_i,
  input  logic                   load_i,
  input  logic [BUF_BYTES*8-1:0] rsp_i,
  input  logic [IDX_W-1:0]       rofs_i,
  input  logic [3:0]             rlen_i,
  output logic [31:0]            rdata_o,
  output logic [BUF_BYTES*8-1:0] data_o,
  output logic [15:0]            len_o
);
  logic [15:0] len_q;
  logic        restart;

  assign restart = wr_i && (wofs_i == '0);

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
    int          rel;
    logic        hit;
    logic [2:0]  sel;
    logic [7:0]  byte_q;

    assign rel = b - int'(wofs_i);
    assign hit = wr_i && (rel >= 0) && (rel < int'(wlen_i));
    assign sel = rel[2:0];
    assign data_o[b*8 +: 8] = byte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q <= '0;
      else if (load_i)  byte_q <= rsp_i[b*8 +: 8];
      else if (hit)     byte_q <= wdata_i[sel*8 +: 8];
      else if (restart) byte_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   len_q <= '0;
    else if (wr_i) len_q <= (restart ? 16'd0 : len_q) + {12'd0, wlen_i};
  end
  assign len_o = len_q;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(rlen_i) && (int'(rofs_i) + k) < int'(BUF_BYTES))
        rdata_o[k*8 +: 8] = data_o[(int'(rofs_i) + k)*8 +: 8];
    end
  end

  // R10
  restart_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> len_o == {12'd0, $past(wlen_i)});
  // R8
  rsp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> data_o == $past(rsp_i));
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
  parameter logic [31:0] WIN_SIZE  = 32'h0000_1000,
  parameter logic [15:0] VENDOR_ID = 16'h1014
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  ofs_i,
  input  logic [3:0]  loc_i,
  input  logic [31:0] val_i,
  input  logic        est_flag_i,
  output logic [31:0] rdata_o,
  output logic        err_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        bk_req_valid_o,
  input  logic        bk_req_ready_i,
  output logic [3:0]  bk_locality_o,
  output logic        bk_cancel_o,
  input  logic        bk_done_i,
  input  logic [7:0]  bk_result_i
);
  // rid, rsvd, lock, selector, ifres, crb, fifo, xfer, rsvd, bypass, loc cap, version, type
  localparam logic [31:0] ID_VAL = {8'h00, 4'h0, 1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 2'd3,
                                    1'b0, 1'b0, 1'b0, 4'd1, 4'd1};
  localparam logic [31:0] SIZE_RST = WIN_SIZE - 32'h80;
  localparam logic [31:0] ADDR_RST = BASE_ADDR + 32'h80;

  logic        assigned_q, granted_q, seized_q, idle_q, err_q, start_q, cancel_q;
  logic [31:0] cmd_size_q, cmd_lo_q, cmd_hi_q, rsp_size_q, rsp_addr_q;
  logic [3:0]  loc_q;
  bk_state_e   st_q;
  logic [7:0]  active_loc;
  logic        start_acc, cancel_hit;

  assign active_loc = assigned_q ? 8'h00 : 8'hFF;
  assign start_acc  = wr_i && ofs_i == OFS_START && val_i == 32'd1 && !start_q
                      && active_loc == {4'h0, loc_i};
  assign cancel_hit = wr_i && ofs_i == OFS_CANCEL && val_i == 32'd1 && start_q;
  assign done_o     = (st_q == BK_WAIT) && bk_done_i;

  always_comb begin
    err_o = 1'b0;
    if (wr_i) begin
      unique case (ofs_i)
        OFS_LOC_CTRL: err_o = !(val_i == 32'd1 || val_i == 32'd2 || val_i == 32'd8);
        OFS_REQ:      err_o = !(val_i == 32'd1 || val_i == 32'd2);
        OFS_CANCEL, OFS_START, OFS_CMD_SIZE, OFS_CMD_LO, OFS_CMD_HI,
        OFS_RSP_SIZE, OFS_RSP_ADDR: err_o = 1'b0;
        default:      err_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      assigned_q <= 1'b0;  granted_q <= 1'b0;  seized_q <= 1'b0;
      idle_q     <= 1'b1;  err_q     <= 1'b0;  start_q  <= 1'b0;
      cancel_q   <= 1'b0;  loc_q     <= '0;    st_q     <= BK_IDLE;
      cmd_size_q <= SIZE_RST;  rsp_size_q <= SIZE_RST;
      cmd_lo_q   <= ADDR_RST;  rsp_addr_q <= ADDR_RST;
      cmd_hi_q   <= '0;
    end else begin
      cancel_q <= cancel_hit;
      if (wr_i) begin
        unique case (ofs_i)
          OFS_LOC_CTRL: begin
            if (val_i == 32'd1) begin
              granted_q <= 1'b1;  seized_q <= 1'b0;  assigned_q <= 1'b1;
            end else if (val_i == 32'd2) begin
              granted_q <= 1'b0;  assigned_q <= 1'b0;
            end
          end
          OFS_REQ: begin
            if (val_i == 32'd1)      idle_q <= 1'b0;
            else if (val_i == 32'd2) idle_q <= 1'b1;
          end
          OFS_CMD_SIZE: cmd_size_q <= val_i;
          OFS_CMD_LO:   cmd_lo_q   <= val_i;
          OFS_CMD_HI:   cmd_hi_q   <= val_i;
          OFS_RSP_SIZE: rsp_size_q <= val_i;
          OFS_RSP_ADDR: rsp_addr_q <= val_i;
          default: ;
        endcase
      end
      unique case (st_q)
        BK_IDLE: if (start_acc) begin
          st_q <= BK_REQ;  start_q <= 1'b1;  loc_q <= loc_i;
        end
        BK_REQ:  if (bk_req_ready_i) st_q <= BK_WAIT;
        BK_WAIT: if (bk_done_i) begin
          st_q <= BK_IDLE;  start_q <= 1'b0;
          if (bk_result_i != 8'd0) err_q <= 1'b1;
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (ofs_i)
      OFS_LOC_STATE: rdata_o = {24'd0, 1'b1, 2'b00, 3'b000, assigned_q, !est_flag_i};
      OFS_LOC_STS:   rdata_o = {30'd0, seized_q, granted_q};
      OFS_ID:        rdata_o = ID_VAL;
      OFS_ID2:       rdata_o = {16'h0000, VENDOR_ID};
      OFS_STS:       rdata_o = {30'd0, idle_q, err_q};
      OFS_START:     rdata_o = {31'd0, start_q};
      OFS_CMD_SIZE:  rdata_o = cmd_size_q;
      OFS_CMD_LO:    rdata_o = cmd_lo_q;
      OFS_CMD_HI:    rdata_o = cmd_hi_q;
      OFS_RSP_SIZE:  rdata_o = rsp_size_q;
      OFS_RSP_ADDR:  rdata_o = rsp_addr_q;
      default:       rdata_o = '0;
    endcase
  end

  assign busy_o         = start_q;
  assign bk_req_valid_o = (st_q == BK_REQ);
  assign bk_locality_o  = loc_q;
  assign bk_cancel_o    = cancel_q;

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_valid_o && !bk_req_ready_i |=> bk_req_valid_o);
  // R7
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_valid_o |-> busy_o);
  // R8
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R9
  cancel_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_cancel_o |-> $past(busy_o));
  // R6
  start_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i && ofs_i == OFS_START && assigned_q && loc_i == 4'd0));
  // R5
  idle_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_q) |-> $past(wr_i && ofs_i == OFS_REQ && val_i == 32'd2));
endmodule

// File: rtl/crb_front.sv
module crb_front
  import crb_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 16,
  parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
  parameter logic [31:0] WIN_SIZE  = 32'h0000_1000,
  parameter logic [15:0] VENDOR_ID = 16'h1014
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mmio_req_i,
  input  logic                   mmio_we_i,
  input  logic [15:0]            mmio_addr_i,
  input  logic [3:0]             mmio_len_i,
  input  logic [63:0]            mmio_wdata_i,
  output logic [31:0]            mmio_rdata_o,
  output logic                   mmio_err_o,
  input  logic                   est_flag_i,
  output logic                   bk_req_valid_o,
  input  logic                   bk_req_ready_i,
  output logic [3:0]             bk_locality_o,
  output logic [15:0]            bk_cmd_len_o,
  output logic [BUF_BYTES*8-1:0] bk_cmd_data_o,
  output logic                   bk_cancel_o,
  input  logic                   bk_done_i,
  input  logic [7:0]             bk_result_i,
  input  logic [BUF_BYTES*8-1:0] bk_rsp_data_i
);
  localparam int unsigned IDX_W   = $clog2(BUF_BYTES);
  localparam logic [12:0] BUF_END = 13'(BUF_BASE) + 13'(BUF_BYTES);

  logic [11:0]      ofs;
  logic             is_buf, busy, done, wr_any, buf_wr, reg_wr, ctrl_err;
  logic [3:0]       clen;
  logic [IDX_W-1:0] bofs;
  logic [31:0]      wval, ctrl_rd, buf_rd;

  assign ofs    = mmio_addr_i[11:0];
  assign is_buf = (ofs >= BUF_BASE) && (mmio_len_i != 4'd0)
                  && (({1'b0, ofs} + {9'd0, mmio_len_i}) <= BUF_END);
  assign clen   = (mmio_len_i > 4'd4) ? 4'd4 : mmio_len_i;
  assign bofs   = IDX_W'(ofs - BUF_BASE);
  assign wval   = le_word(mmio_wdata_i[31:0], clen);
  assign wr_any = mmio_req_i && mmio_we_i;
  assign buf_wr = wr_any && is_buf && !busy;
  // over-long register writes only tolerated at the response address
  assign reg_wr = wr_any && !is_buf && (mmio_len_i != 4'd0)
                  && (mmio_len_i <= 4'd4 || mmio_addr_i[7:0] == OFS_RSP_ADDR);

  assign mmio_err_o = wr_any && ((is_buf && busy) || (!is_buf && !reg_wr) || ctrl_err);

  crb_ctrl #(
    .BASE_ADDR (BASE_ADDR),
    .WIN_SIZE  (WIN_SIZE),
    .VENDOR_ID (VENDOR_ID)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (reg_wr),
    .ofs_i          (mmio_addr_i[7:0]),
    .loc_i          (mmio_addr_i[15:12]),
    .val_i          (wval),
    .est_flag_i     (est_flag_i),
    .rdata_o        (ctrl_rd),
    .err_o          (ctrl_err),
    .busy_o         (busy),
    .done_o         (done),
    .bk_req_valid_o (bk_req_valid_o),
    .bk_req_ready_i (bk_req_ready_i),
    .bk_locality_o  (bk_locality_o),
    .bk_cancel_o    (bk_cancel_o),
    .bk_done_i      (bk_done_i),
    .bk_result_i    (bk_result_i)
  );

  crb_dbuf #(
    .BUF_BYTES (BUF_BYTES),
    .IDX_W     (IDX_W)
  ) u_dbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (buf_wr),
    .wofs_i  (bofs),
    .wlen_i  (mmio_len_i),
    .wdata_i (mmio_wdata_i),
    .load_i  (done),
    .rsp_i   (bk_rsp_data_i),
    .rofs_i  (bofs),
    .rlen_i  (clen),
    .rdata_o (buf_rd),
    .data_o  (bk_cmd_data_o),
    .len_o   (bk_cmd_len_o)
  );

  always_comb begin
    if (!mmio_req_i || mmio_we_i) mmio_rdata_o = '0;
    else if (is_buf)              mmio_rdata_o = buf_rd;
    else if (mmio_len_i <= 4'd4)  mmio_rdata_o = ctrl_rd;
    else                          mmio_rdata_o = '0;
  end

  // R11
  buf_protect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done |=> $stable(bk_cmd_data_o) && $stable(bk_cmd_len_o));
  // R12
  long_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any && !is_buf && mmio_len_i > 4'd4 && mmio_addr_i[7:0] != OFS_RSP_ADDR |-> mmio_err_o);
endmodule

// File: tb/crb_front_bench.sv
module crb_front_bench;
  localparam int BUF = 16;
  localparam logic [31:0] BASE = 32'hFED4_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, est = 1'b1, rdy = 0, done = 0;
  logic [15:0] addr = '0;
  logic [3:0]  len = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  res = '0;
  logic [BUF*8-1:0] rsp = '0;
  logic [31:0] rdata;
  logic        err, valid, cancel;
  logic [3:0]  bloc;
  logic [15:0] blen;
  logic [BUF*8-1:0] bdata;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  crb_front #(.BUF_BYTES(BUF), .BASE_ADDR(BASE)) u_crb_front (
    .clk_i(clk), .rst_ni(rst_n), .mmio_req_i(req), .mmio_we_i(we), .mmio_addr_i(addr),
    .mmio_len_i(len), .mmio_wdata_i(wdata), .mmio_rdata_o(rdata), .mmio_err_o(err),
    .est_flag_i(est), .bk_req_valid_o(valid), .bk_req_ready_i(rdy), .bk_locality_o(bloc),
    .bk_cmd_len_o(blen), .bk_cmd_data_o(bdata), .bk_cancel_o(cancel), .bk_done_i(done),
    .bk_result_i(res), .bk_rsp_data_i(rsp));

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] n, input logic [63:0] d, output bit e);
    @(negedge clk);
    req = 1; we = 1; addr = a; len = n; wdata = d;
    #1 e = err;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [3:0] n, output logic [31:0] v);
    @(negedge clk);
    req = 1; we = 0; addr = a; len = n;
    #1 v = rdata;
    req = 0;
  endtask

  function automatic bit is_def(input int o);
    return o inside {'h00, 'h08, 'h0C, 'h30, 'h34, 'h40, 'h44, 'h48, 'h4C,
                     'h58, 'h5C, 'h60, 'h64, 'h68};
  endfunction

  // takes the request after one held cycle, then completes it
  task automatic complete(input logic [7:0] r, input logic [BUF*8-1:0] d, input bit wr_too);
    bit e;
    @(negedge clk);
    check("R7 valid held while not ready", valid, 1);
    rdy = 1;
    @(negedge clk);
    rdy = 0;
    check("R7 valid drops after ready", valid, 0);
    done = 1; res = r; rsp = d;
    if (wr_too) begin
      req = 1; we = 1; addr = 16'h0080; len = 1; wdata = 64'h77;
      #1 e = err;
      check("R11 write in done cycle flagged", e, 1);
    end
    @(negedge clk);
    done = 0; req = 0; we = 0;
  endtask

  logic [31:0] v;
  bit e;
  bit as_m, gr_m, idle_m;
  logic [BUF*8-1:0] exp_d, rsp_p;
  int exp_len;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(16'h0000, 4, v); check("R1 locality state", v, 32'h80);
    rd(16'h0044, 4, v); check("R1 control status", v, 32'h2);
    rd(16'h004C, 4, v); check("R1 start", v, 0);
    rd(16'h0030, 4, v); check("R2 interface id", v, 32'h0002_5811);
    rd(16'h0034, 4, v); check("R2 id2", v, 32'h0000_1014);
    wr(16'h0030, 4, 64'hFFFF_FFFF, e); check("R2 id write flagged", e, 1);
    rd(16'h0030, 4, v); check("R2 id unchanged", v, 32'h0002_5811);
    rd(16'h0058, 4, v); check("R3 cmd size", v, 32'hF80);
    rd(16'h0064, 4, v); check("R3 rsp size", v, 32'hF80);
    rd(16'h005C, 4, v); check("R3 cmd lo", v, BASE + 32'h80);
    rd(16'h0068, 4, v); check("R3 rsp addr", v, BASE + 32'h80);
    rd(16'h0060, 4, v); check("R3 cmd hi", v, 0);
    est = 0;
    rd(16'h0000, 4, v); check("R14 established bit", v, 32'h81);
    est = 1;

    // undefined offsets
    for (int o = 0; o < 'h80; o += 4) begin
      if (!is_def(o)) begin
        wr(16'(o), 4, 64'hFFFF_FFFF, e); check("R13 undefined write flagged", e, 1);
        rd(16'(o), 4, v); check("R13 undefined reads zero", v, 0);
      end
    end

    // locality control sweep
    as_m = 0; gr_m = 0;
    for (int c = 0; c < 16; c++) begin
      wr(16'h0008, 4, 64'(c), e);
      check("R4 error flag", e, !(c == 1 || c == 2 || c == 8));
      if (c == 1) begin as_m = 1; gr_m = 1; end
      if (c == 2) begin as_m = 0; gr_m = 0; end
      rd(16'h0000, 4, v); check("R4 assigned", v, 32'h80 | (32'(as_m) << 1));
      rd(16'h000C, 4, v); check("R4 granted", v, 32'(gr_m));
    end

    // control request sweep
    idle_m = 1;
    for (int c = 0; c < 8; c++) begin
      wr(16'h0040, 4, 64'(c), e);
      check("R5 error flag", e, !(c == 1 || c == 2));
      if (c == 1) idle_m = 0;
      if (c == 2) idle_m = 1;
      rd(16'h0044, 4, v); check("R5 idle bit", v, 32'(idle_m) << 1);
    end

    // length and partial writes
    wr(16'h0058, 8, 64'h1111_2222_3333_4444, e); check("R12 long write flagged", e, 1);
    rd(16'h0058, 4, v); check("R12 long write ignored", v, 32'hF80);
    wr(16'h0068, 8, 64'hAAAA_AAAA_1234_5678, e); check("R12 rsp addr long ok", e, 0);
    rd(16'h0068, 4, v); check("R12 rsp addr low word", v, 32'h1234_5678);
    wr(16'h0060, 2, 64'hFFFF_BEEF, e);
    rd(16'h0060, 4, v); check("R3 partial little-endian", v, 32'h0000_BEEF);
    wr(16'h0058, 4, 64'h40, e);
    rd(16'h0058, 4, v); check("R3 cmd size write", v, 32'h40);

    // buffer sweep
    for (int n = 1; n <= 4; n++) begin
      for (int o = 0; o <= BUF - n; o++) begin
        logic [31:0] p;
        p = 32'h0;
        for (int k = 0; k < n; k++) p[k*8 +: 8] = 8'(o * 16 + n + k);
        wr(16'h0080, 1, 64'h11, e);
        exp_d = '0; exp_d[7:0] = 8'h11; exp_len = 1;
        wr(16'(16'h80 + o), 4'(n), {32'h0, p}, e);
        if (o == 0) begin exp_d = '0; exp_len = 0; end
        for (int k = 0; k < n; k++) exp_d[(o + k)*8 +: 8] = p[k*8 +: 8];
        exp_len += n;
        rd(16'(16'h80 + o), 4'(n), v); check("R10 readback", v, p);
        check("R10 length", blen, 128'(exp_len));
        check("R10 contents", bdata, exp_d);
      end
    end
    wr(16'h0080, 8, 64'h0807_0605_0403_0201, e);
    check("R10 eight-byte length", blen, 8);
    wr(16'(16'h80 + BUF - 1), 2, 64'hFFFF, e);
    check("R10 overrun flagged", e, 1);
    check("R10 overrun no effect", bdata, 128'h0807_0605_0403_0201);

    // start gating: unassigned
    wr(16'h0008, 4, 64'd2, e);
    for (int l = 0; l < 16; l++) begin
      wr({4'(l), 12'h04C}, 4, 64'd1, e);
      rd(16'h004C, 4, v); check("R6 unassigned start ignored", {v[0], valid}, 2'b00);
    end
    wr(16'h0008, 4, 64'd1, e);
    for (int l = 1; l < 16; l++) begin
      wr({4'(l), 12'h04C}, 4, 64'd1, e);
      rd(16'h004C, 4, v); check("R6 foreign locality ignored", {v[0], valid}, 2'b00);
    end
    wr(16'h004C, 4, 64'd3, e);
    rd(16'h004C, 4, v); check("R6 wrong value ignored", v, 0);

    // command round trip, success
    wr(16'h0080, 4, 64'hDDCC_BBAA, e);
    wr(16'h0084, 2, 64'hFFEE, e);
    exp_d = '0; exp_d[47:0] = 48'hFFEE_DDCC_BBAA;
    wr(16'h004C, 4, 64'd1, e);
    check("R7 valid after start", valid, 1);
    check("R7 command length", blen, 6);
    check("R7 command bytes", bdata, exp_d);
    check("R7 locality", bloc, 0);
    rd(16'h004C, 4, v); check("R7 start bit set", v, 1);
    wr(16'h0048, 4, 64'd1, e);
    check("R9 cancel pulse while busy", cancel, 1);
    @(negedge clk); check("R9 cancel one cycle", cancel, 0);
    wr(16'h0082, 1, 64'h99, e); check("R11 busy write flagged", e, 1);
    check("R11 busy write ignored", bdata, exp_d);
    for (int k = 0; k < BUF; k++) rsp_p[k*8 +: 8] = 8'hA0 + 8'(k);
    complete(8'd0, rsp_p, 0);
    rd(16'h004C, 4, v); check("R8 start cleared", v, 0);
    rd(16'h0044, 4, v); check("R8 no error on success", v, 32'(idle_m) << 1);
    rd(16'h0080, 4, v); check("R8 response in buffer", v, 32'hA3A2_A1A0);
    wr(16'h0048, 4, 64'd1, e);
    check("R9 no cancel while idle", cancel, 0);

    // round trip with failure and simultaneous buffer write
    for (int k = 0; k < BUF; k++) rsp_p[k*8 +: 8] = 8'h50 + 8'(k);
    exp_len = int'(blen);
    wr(16'h004C, 4, 64'd1, e);
    complete(8'd5, rsp_p, 1);
    rd(16'h0044, 4, v); check("R8 error bit set", v, (32'(idle_m) << 1) | 32'h1);
    rd(16'h0080, 1, v); check("R11 response wins over write", v, 32'h50);
    check("R11 length kept", blen, 128'(exp_len));
    check("R8 full response", bdata, rsp_p);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule